// File: doc/BRIEF.md
# Reloadable Countdown Interval Timer

This block is a programmable down-counter that counts prescaled ticks and raises a sticky expiry flag each time the count arrives at zero. Software, through a register bus outside this block, writes a reload value. The write stores the value and restarts the count from it. A tick enable pulse, made by an external prescaler, lowers the count by one for each cycle in which it is high.

A recycle control bit selects the mode. In periodic mode the timer takes the stored value again at each expiry. In one-shot mode the timer halts at zero, and only a fresh write of the reload value starts it again. Writing zero puts the timer into an idle, powered-down state in which ticks have no effect.

The expiry flag stays set until a read-to-clear strobe removes it. The flag goes to a separate interrupt block. All pins are plain control and status signals. No data stream crosses the boundary, so the block has no valid/ready handshake and no back-pressure.

Top module: `reload_timer`

## Requirements
- R1: After reset the count reads 0, the active output is 0 and the expiry flag is 0.
- R2: A load write of a nonzero value sets the count to that value and makes the active output 1 on the next cycle.
- R3: While active, each cycle with the tick enable high lowers the count by exactly one. Cycles without a tick leave the count unchanged.
- R4: With recycle high, a tick taken at count 1 reloads the stored value into the count, keeps the timer active and sets the expiry flag.
- R5: With recycle low, a tick taken at count 1 leaves the count at 0 and the active output at 0, and sets the expiry flag. Later ticks change neither the count nor the flag.
- R6: After a one-shot halt, counting resumes only when a new load write arrives.
- R7: A load write of zero makes the count 0 and the active output 0. Ticks are then ignored and no expiry occurs.
- R8: The expiry flag holds at 1 until a clear strobe. A clear strobe makes it 0 on the next cycle when no expiry occurs in the same cycle.
- R9: When a clear strobe and an expiry fall in the same cycle, the flag ends at 1.
- R10: When a load write and a tick fall in the same cycle, the load wins. The count takes the new value, even from count 1, and no expiry occurs.
- R11: The recycle bit is sampled only in the expiry cycle. A change made while the timer is counting decides the mode of the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Load write strobe |
| ld_value | input | W (8) | Reload value for a load write |
| recycle_en | input | 1 | 1 selects periodic mode, 0 selects one-shot mode |
| tick_en | input | 1 | Prescaled count enable, one decrement per high cycle |
| flag_clr | input | 1 | Read-to-clear strobe for the expiry flag |
| count_o | output | W (8) | Current count |
| active_o | output | 1 | Timer is counting |
| expired_o | output | 1 | Sticky expiry flag |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a load write and a tick. The bench brings the count to 1, then asserts both strobes in one cycle. The check expects the new load value on the count and a clear flag, which shows the expiry was suppressed.

The second pair is an expiry and a flag clear. The bench holds the clear strobe in the cycle of the expiring tick. The check expects the flag to read 1 afterwards, and then to read 0 after a lone clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/tmr_loadreg.sv
module tmr_loadreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_we,
  input  logic [W-1:0] ld_value,
  output logic [W-1:0] stored
);
  always_ff @(posedge clk) begin
    if (!rst_n)     stored <= '0;
    else if (ld_we) stored <= ld_value;
  end

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> stored == $past(ld_value));
  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_we |=> $stable(stored));
endmodule

// File: rtl/tmr_down.sv
module tmr_down
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_we,
  input  logic [W-1:0] ld_value,
  input  logic [W-1:0] stored,
  input  logic         recycle_en,
  input  logic         tick_en,
  output logic [W-1:0] cnt,
  output logic         active,
  output logic         expire_evt
);
  localparam logic [W-1:0] ONE = W'(1);

  tmr_state_e state;
  logic       step;

  assign active     = (state == TMR_RUN);
  assign step       = active && tick_en && !ld_we;
  assign expire_evt = step && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      state <= TMR_IDLE;
    end else if (ld_we) begin
      cnt   <= ld_value;
      state <= (ld_value != '0) ? TMR_RUN : TMR_IDLE;
    end else if (expire_evt) begin
      if (recycle_en) begin
        cnt   <= stored;
      end else begin
        cnt   <= '0;
        state <= TMR_IDLE;
      end
    end else if (step) begin
      cnt <= cnt - ONE;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> cnt == $past(ld_value));
  assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick_en && !ld_we && cnt > ONE) |=> cnt == $past(cnt) - ONE);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_we) |=> $stable(cnt));
  assert_recycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && recycle_en) |=> (cnt == $past(stored)) && active);
  assert_oneshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !recycle_en) |=> !active && cnt == '0);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !ld_we) |=> !active && $stable(cnt));
  assert_loadwin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> !expire_evt);
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag);
  assert_setwin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_we,
  input  logic [W-1:0] ld_value,
  input  logic         recycle_en,
  input  logic         tick_en,
  input  logic         flag_clr,
  output logic [W-1:0] count_o,
  output logic         active_o,
  output logic         expired_o
);
  logic [W-1:0] stored;
  logic         expire_evt;

  tmr_loadreg #(.W(W)) u_loadreg (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_value(ld_value), .stored(stored)
  );

  tmr_down #(.W(W)) u_down (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_value(ld_value), .stored(stored),
    .recycle_en(recycle_en), .tick_en(tick_en), .cnt(count_o), .active(active_o),
    .expire_evt(expire_evt)
  );

  tmr_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(expire_evt), .clr(flag_clr), .flag(expired_o)
  );

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> count_o == '0 && !active_o && !expired_o);
  assert_noexp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !expire_evt);
endmodule

// File: tb/reload_timer_test.sv
module reload_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_we = 1'b0;
  logic [W-1:0] ld_value = '0;
  logic         recycle_en = 1'b0;
  logic         tick_en = 1'b0;
  logic         flag_clr = 1'b0;
  logic [W-1:0] count_o;
  logic         active_o;
  logic         expired_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_timer #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_value(ld_value),
    .recycle_en(recycle_en), .tick_en(tick_en), .flag_clr(flag_clr),
    .count_o(count_o), .active_o(active_o), .expired_o(expired_o)
  );

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic cyc(input bit we, input int val, input bit tk, input bit clr);
    ld_we = we; ld_value = W'(val); tick_en = tk; flag_clr = clr;
    @(negedge clk);
    ld_we = 1'b0; tick_en = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic expect_state(input string req, input int c, input int a, input int f);
    check({req, " count"}, count_o, c);
    check({req, " active"}, active_o, a);
    check({req, " flag"}, expired_o, f);
  endtask

  task automatic t_reset_R1();
    expect_state("R1", 0, 0, 0);
  endtask

  task automatic t_load_dec_R2_R3();
    recycle_en = 1'b1;
    cyc(1, 5, 0, 0);
    expect_state("R2", 5, 1, 0);
    cyc(0, 0, 1, 0);
    check("R3 dec", count_o, 4);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check("R3 no tick", count_o, 4);
    cyc(0, 0, 1, 0);
    check("R3 dec2", count_o, 3);
  endtask

  task automatic t_periodic_R4_R8();
    recycle_en = 1'b1;
    cyc(1, 3, 0, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    expect_state("R4 pre", 1, 1, 0);
    cyc(0, 0, 1, 0);
    expect_state("R4 reload", 3, 1, 1);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0);
    check("R8 sticky", expired_o, 1);
    cyc(0, 0, 0, 1);
    check("R8 clear", expired_o, 0);
    check("R4 still counting", count_o, 2);
  endtask

  task automatic t_oneshot_R5_R6();
    recycle_en = 1'b0;
    cyc(1, 2, 0, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    expect_state("R5 halt", 0, 0, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    expect_state("R5 stays", 0, 0, 0);
    recycle_en = 1'b1;
    cyc(0, 0, 1, 0);
    expect_state("R6 no resume", 0, 0, 0);
    cyc(1, 2, 0, 0);
    expect_state("R6 reload", 2, 1, 0);
    cyc(0, 0, 1, 0);
    check("R6 counting", count_o, 1);
  endtask

  task automatic t_zero_R7();
    recycle_en = 1'b1;
    cyc(1, 4, 0, 1);
    cyc(0, 0, 1, 0);
    cyc(1, 0, 0, 0);
    expect_state("R7 off", 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
    expect_state("R7 ticks ignored", 0, 0, 0);
  endtask

  task automatic t_load_tick_R10();
    recycle_en = 1'b1;
    cyc(1, 2, 0, 1);
    cyc(0, 0, 1, 0);
    check("R10 pre", count_o, 1);
    cyc(1, 6, 1, 0);
    expect_state("R10 load wins", 6, 1, 0);
  endtask

  task automatic t_clr_set_R9();
    recycle_en = 1'b1;
    cyc(1, 1, 0, 1);
    cyc(0, 0, 1, 0);
    check("R9 first expiry", expired_o, 1);
    cyc(0, 0, 1, 1);
    check("R9 set beats clear", expired_o, 1);
    cyc(0, 0, 0, 1);
    check("R9 lone clear", expired_o, 0);
  endtask

  task automatic t_recycle_change_R11();
    recycle_en = 1'b1;
    cyc(1, 2, 0, 1);
    cyc(0, 0, 1, 0);
    recycle_en = 1'b0;
    cyc(0, 0, 1, 0);
    expect_state("R11 to oneshot", 0, 0, 1);
    recycle_en = 1'b0;
    cyc(1, 2, 0, 1);
    cyc(0, 0, 1, 0);
    recycle_en = 1'b1;
    cyc(0, 0, 1, 0);
    expect_state("R11 to periodic", 2, 1, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_R1();
    t_load_dec_R2_R3();
    t_periodic_R4_R8();
    t_oneshot_R5_R6();
    t_zero_R7();
    t_load_tick_R10();
    t_clr_set_R9();
    t_recycle_change_R11();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule